// File: doc/BRIEF.md
# Registered Command Buffer with Delayed Parity Check

This block sits on a memory address/command bus between a controller and a set of DRAM devices. On each rising clock edge it registers a 22-bit command/address word, two clock-enable lines, two termination-control lines and four active-low chip selects. It drives every registered value onto two identical output copies, A and B, so that two loads can be fed from one register stage.

The command/address word can be gated by the chip selects. With the gating enable high, the word's outputs take a new value only on edges where at least one chip select is low; otherwise they hold. With gating off, the word follows its input on every edge. The clock-enable, termination and chip-select outputs are never gated. Only the two lower chip selects have outputs; the upper two only take part in the gating decision.

A parity bit for each word arrives one clock after the word itself. The block delays the word to meet its parity bit and checks that the 22 data bits and the parity bit together hold an even number of ones. A failure drives an active-low error flag for two cycles, one cycle later than the check itself produces it.

Top module: `cmdreg_buffer`

## Requirements
- R1: Outputs `q_a`/`q_b`, `cke_a`/`cke_b`, `odt_a`/`odt_b` and `cs_n_a`/`cs_n_b` always carry identical values.
- R2: With `gate_en` = 1, `q_a` takes `d_in` on an edge only if at least one bit of `cs_n_in[3:0]` is 0 (any of the four selects, including bits 2 and 3); if all four are 1 it holds its value.
- R3: With `gate_en` = 0, `q_a` takes `d_in` on every edge, whatever `cs_n_in` is.
- R4: `cke_a` and `odt_a` take `cke_in` and `odt_in` on every edge, independent of `gate_en` and the chip selects.
- R5: `cs_n_a` takes `cs_n_in[1:0]` on every edge; `cs_n_in[3:2]` have no output.
- R6: `par_in` sampled at edge k+1 belongs to the word sampled at edge k. The word is faulty when the XOR of its 22 bits and that parity bit is 1. Words not accepted by the gate (R2) are never checked.
- R7: For a faulty word sampled at edge k, `err_n` is 0 after edges k+3 and k+4 and returns to 1 after edge k+5, unless another fault extends it.
- R8: A fault detected while a pulse is active restarts the two-cycle low period from the new detection, so the low intervals of overlapping faults merge.
- R9: Synchronous active-high `rst` sets `q_a`, `q_b`, `cke_*`, `odt_*` to 0, `cs_n_a`/`cs_n_b` to all ones and `err_n` to 1, and discards any fault still in the check pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| gate_en | input | 1 | 1: word is gated by the chip selects |
| d_in | input | 22 | Command/address word |
| cke_in | input | 2 | Clock-enable lines |
| odt_in | input | 2 | Termination-control lines |
| cs_n_in | input | 4 | Chip selects, active low |
| par_in | input | 1 | Parity bit for the previous edge's word |
| q_a | output | 22 | Registered word, copy A |
| q_b | output | 22 | Registered word, copy B |
| cke_a | output | 2 | Registered clock enables, copy A |
| cke_b | output | 2 | Registered clock enables, copy B |
| odt_a | output | 2 | Registered termination lines, copy A |
| odt_b | output | 2 | Registered termination lines, copy B |
| cs_n_a | output | 2 | Registered chip selects 0 and 1, copy A |
| cs_n_b | output | 2 | Registered chip selects 0 and 1, copy B |
| err_n | output | 1 | Parity error flag, active low |

## Verification
The word, clock-enable, termination and chip-select outputs are due one edge after the inputs they capture, so the driver queues the expected output set for each edge before that edge and the monitor compares it a quarter period after the edge. The error flag is due three and four edges after its word (two and three after its parity bit); the driver records those future low cycles in a table keyed by edge number when it sends the parity bit, and every queued entry reads the flag expected for its own edge from that table. A reset entry drops every pending low cycle from the reset edge on, matching the discarded pipeline.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

  // Default geometry of the command register
  localparam int unsigned CMD_DATA_W   = 22;
  localparam int unsigned CMD_CS_W     = 4;
  localparam int unsigned CMD_CS_OUT_W = 2;
  localparam int unsigned CMD_CKE_W    = 2;
  localparam int unsigned CMD_ODT_W    = 2;
  localparam int unsigned CMD_COPIES   = 2;
  localparam int unsigned CMD_ERR_HOLD = 2;

  // True when any of the lowest 'width' active-low selects is asserted.
  function automatic logic any_select_low(input logic [31:0] sel_n,
                                          input int unsigned width);
    logic hit;
    hit = 1'b0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < width && !sel_n[i]) hit = 1'b1;
    end
    return hit;
  endfunction

  // Even parity over word and parity bit; returns 1 on a fault.
  // The word is zero-extended by the caller (width up to 64).
  function automatic logic parity_fault(input logic [63:0] word,
                                        input logic par);
    return (^word) ^ par;
  endfunction

endpackage

// File: rtl/cmdreg_gate.sv
module cmdreg_gate #(
  parameter int unsigned CS_W = cmdreg_pkg::CMD_CS_W
) (
  input  logic            gate_en,
  input  logic [CS_W-1:0] cs_n,
  output logic            accept
);
  logic sel_seen;

  // Any select low, including the ones that are not re-driven.
  assign sel_seen = cmdreg_pkg::any_select_low(32'(cs_n), CS_W);
  assign accept   = !gate_en || sel_seen;

endmodule

// File: rtl/cmdreg_copy.sv
module cmdreg_copy #(
  parameter int unsigned DATA_W   = cmdreg_pkg::CMD_DATA_W,
  parameter int unsigned CKE_W    = cmdreg_pkg::CMD_CKE_W,
  parameter int unsigned ODT_W    = cmdreg_pkg::CMD_ODT_W,
  parameter int unsigned CS_OUT_W = cmdreg_pkg::CMD_CS_OUT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [DATA_W-1:0]   d,
  input  logic [CKE_W-1:0]    cke,
  input  logic [ODT_W-1:0]    odt,
  input  logic [CS_OUT_W-1:0] cs_n,
  output logic [DATA_W-1:0]   q,
  output logic [CKE_W-1:0]    cke_q,
  output logic [ODT_W-1:0]    odt_q,
  output logic [CS_OUT_W-1:0] cs_n_q
);

  // Gated word register
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // Ungated side-band registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q  <= '0;
      odt_q  <= '0;
      cs_n_q <= '1;
    end else begin
      cke_q  <= cke;
      odt_q  <= odt;
      cs_n_q <= cs_n;
    end
  end

  AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q)); // R2
  AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(d)); // R3
  AST_SIDEBAND_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cke_q == $past(cke)) && (odt_q == $past(odt))); // R4

endmodule

// File: rtl/cmdreg_parity.sv
module cmdreg_parity #(
  parameter int unsigned DATA_W = cmdreg_pkg::CMD_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] d_in,
  input  logic              par_in,
  output logic              mismatch,
  output logic              err_det
);
  // Stage 1: word and its gate decision, one edge old
  logic [DATA_W-1:0] dly_data;
  logic              dly_valid;
  // Stage 2: word aligned with its parity bit
  logic [DATA_W-1:0] chk_data;
  logic              chk_valid;
  logic              chk_par;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_data  <= '0;
      dly_valid <= 1'b0;
      chk_data  <= '0;
      chk_valid <= 1'b0;
      chk_par   <= 1'b0;
      err_det   <= 1'b0;
    end else begin
      dly_data  <= d_in;
      dly_valid <= accept;
      chk_data  <= dly_data;
      chk_valid <= dly_valid;
      chk_par   <= par_in;
      err_det   <= mismatch;
    end
  end

  assign mismatch = chk_valid && cmdreg_pkg::parity_fault(64'(chk_data), chk_par);

  AST_ONLY_ACCEPTED_CHECKED: assert property (@(posedge clk) disable iff (rst)
    err_det |-> $past(accept, 3)); // R6
  AST_PARITY_RULE: assert property (@(posedge clk) disable iff (rst)
    err_det |-> ((^$past(d_in, 3)) ^ $past(par_in, 2))); // R6

endmodule

// File: rtl/cmdreg_errpulse.sv
module cmdreg_errpulse #(
  parameter int unsigned HOLD = cmdreg_pkg::CMD_ERR_HOLD
) (
  input  logic clk,
  input  logic rst,
  input  logic err_det,
  output logic err_n
);
  localparam int unsigned CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] hold_cnt;

  // Loading the counter is the extra alignment stage after detection.
  always_ff @(posedge clk) begin
    if (rst)                 hold_cnt <= '0;
    else if (err_det)        hold_cnt <= CNT_W'(HOLD);
    else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
  end

  assign err_n = (hold_cnt == '0);

  AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(err_n) |-> $past(err_det)); // R7
  AST_PULSE_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    $fell(err_n) |=> !err_n); // R7
  AST_RESTART_EXTENDS: assert property (@(posedge clk) disable iff (rst)
    err_det |=> !err_n ##1 !err_n); // R8

endmodule

// File: rtl/cmdreg_buffer.sv
module cmdreg_buffer #(
  parameter int unsigned DATA_W   = cmdreg_pkg::CMD_DATA_W,
  parameter int unsigned CS_W     = cmdreg_pkg::CMD_CS_W,
  parameter int unsigned CS_OUT_W = cmdreg_pkg::CMD_CS_OUT_W,
  parameter int unsigned CKE_W    = cmdreg_pkg::CMD_CKE_W,
  parameter int unsigned ODT_W    = cmdreg_pkg::CMD_ODT_W,
  parameter int unsigned ERR_HOLD = cmdreg_pkg::CMD_ERR_HOLD
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gate_en,
  input  logic [DATA_W-1:0]   d_in,
  input  logic [CKE_W-1:0]    cke_in,
  input  logic [ODT_W-1:0]    odt_in,
  input  logic [CS_W-1:0]     cs_n_in,
  input  logic                par_in,
  output logic [DATA_W-1:0]   q_a,
  output logic [DATA_W-1:0]   q_b,
  output logic [CKE_W-1:0]    cke_a,
  output logic [CKE_W-1:0]    cke_b,
  output logic [ODT_W-1:0]    odt_a,
  output logic [ODT_W-1:0]    odt_b,
  output logic [CS_OUT_W-1:0] cs_n_a,
  output logic [CS_OUT_W-1:0] cs_n_b,
  output logic                err_n
);
  localparam int unsigned COPIES = cmdreg_pkg::CMD_COPIES;

  // Named internal events
  logic accept;
  logic mismatch;
  logic err_det;

  logic [DATA_W-1:0]   q_copy    [COPIES];
  logic [CKE_W-1:0]    cke_copy  [COPIES];
  logic [ODT_W-1:0]    odt_copy  [COPIES];
  logic [CS_OUT_W-1:0] cs_copy   [COPIES];

  cmdreg_gate #(.CS_W(CS_W)) u_gate (
    .gate_en (gate_en),
    .cs_n    (cs_n_in),
    .accept  (accept)
  );

  // One independent register set per output copy
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    cmdreg_copy #(
      .DATA_W   (DATA_W),
      .CKE_W    (CKE_W),
      .ODT_W    (ODT_W),
      .CS_OUT_W (CS_OUT_W)
    ) u_copy (
      .clk    (clk),
      .rst    (rst),
      .load   (accept),
      .d      (d_in),
      .cke    (cke_in),
      .odt    (odt_in),
      .cs_n   (cs_n_in[CS_OUT_W-1:0]),
      .q      (q_copy[c]),
      .cke_q  (cke_copy[c]),
      .odt_q  (odt_copy[c]),
      .cs_n_q (cs_copy[c])
    );
  end

  assign q_a    = q_copy[0];
  assign q_b    = q_copy[1];
  assign cke_a  = cke_copy[0];
  assign cke_b  = cke_copy[1];
  assign odt_a  = odt_copy[0];
  assign odt_b  = odt_copy[1];
  assign cs_n_a = cs_copy[0];
  assign cs_n_b = cs_copy[1];

  cmdreg_parity #(.DATA_W(DATA_W)) u_parity (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .d_in     (d_in),
    .par_in   (par_in),
    .mismatch (mismatch),
    .err_det  (err_det)
  );

  cmdreg_errpulse #(.HOLD(ERR_HOLD)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .err_det (err_det),
    .err_n   (err_n)
  );

  AST_COPIES_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (q_a == q_b) && (cke_a == cke_b) && (odt_a == odt_b) && (cs_n_a == cs_n_b)); // R1
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (gate_en && (&cs_n_in)) |=> $stable(q_a)); // R2
  AST_UNGATED_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !gate_en |=> q_a == $past(d_in)); // R3
  AST_CS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cs_n_a == $past(cs_n_in[CS_OUT_W-1:0])); // R5
  AST_CHECK_FEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> ##1 !err_n); // R7
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (q_a == '0) && (cke_a == '0) && (odt_a == '0) && (&cs_n_a) && err_n); // R9

endmodule

// File: tb/cmdreg_buffer_tb.sv
module cmdreg_buffer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gate_en = 1'b0;
  logic [21:0] d_in = '0;
  logic [1:0]  cke_in = '0;
  logic [1:0]  odt_in = '0;
  logic [3:0]  cs_n_in = 4'hF;
  logic        par_in = 1'b0;
  logic [21:0] q_a, q_b;
  logic [1:0]  cke_a, cke_b, odt_a, odt_b, cs_n_a, cs_n_b;
  logic        err_n;

  always #4 clk = ~clk; // 125 MHz

  cmdreg_buffer u_dut (
    .clk(clk), .rst(rst), .gate_en(gate_en), .d_in(d_in),
    .cke_in(cke_in), .odt_in(odt_in), .cs_n_in(cs_n_in), .par_in(par_in),
    .q_a(q_a), .q_b(q_b), .cke_a(cke_a), .cke_b(cke_b),
    .odt_a(odt_a), .odt_b(odt_b), .cs_n_a(cs_n_a), .cs_n_b(cs_n_b),
    .err_n(err_n)
  );

  typedef struct {
    logic [21:0] q;
    logic [1:0]  cke;
    logic [1:0]  odt;
    logic [1:0]  cs;
    logic        err_n;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  bit          low_at[int];
  int          checks = 0;
  int          fails  = 0;
  int          edge_no = 0;
  bit          done = 1'b0;

  // Bench model state
  logic [21:0] m_q = '0;
  logic [21:0] m_prev_d = '0;
  logic        m_prev_acc = 1'b0;
  logic [21:0] last_d = '0;
  logic [21:0] lfsr = 22'h2A5C3;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s edge %0d: actual=%h expected=%h", tag, what, edge_no, act, exp);
    end
  endtask

  // Driver: applies one edge worth of inputs and queues what must follow it.
  task automatic step(input logic [21:0] d, input logic [3:0] csn, input logic gate,
                      input logic [1:0] cke, input logic [1:0] odt,
                      input logic bad, input logic rst_v, input string tag);
    exp_t e;
    logic par;
    logic acc;
    int   c;
    @(negedge clk);
    par = (^last_d) ^ bad;
    rst = rst_v; gate_en = gate; d_in = d; cs_n_in = csn;
    cke_in = cke; odt_in = odt; par_in = par;
    edge_no++;
    c = edge_no;
    if (rst_v) begin
      m_q = '0; e.cke = '0; e.odt = '0; e.cs = 2'b11; e.err_n = 1'b1;
      m_prev_acc = 1'b0;
      foreach (low_at[k]) if (k >= c) low_at.delete(k);
    end else begin
      // R6: parity at this edge covers the word of the previous edge
      if (m_prev_acc && ((^m_prev_d) ^ par)) begin
        low_at[c + 2] = 1'b1;
        low_at[c + 3] = 1'b1;
      end
      acc = !gate || (csn != 4'hF);
      if (acc) m_q = d;
      m_prev_acc = acc;
      e.cke = cke; e.odt = odt; e.cs = csn[1:0];
      e.err_n = !low_at.exists(c);
    end
    m_prev_d = d;
    last_d = d;
    e.q = m_q;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares a quarter period after each edge.
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(q_a == e.q, e.tag, "q_a", 32'(q_a), 32'(e.q));
      check(q_b == q_a, "R1", "q_b copy", 32'(q_b), 32'(q_a));
      check(cke_a == e.cke && cke_b == e.cke, "R4", "cke", {cke_b, 14'h0, cke_a}, {e.cke, 14'h0, e.cke});
      check(odt_a == e.odt && odt_b == e.odt, "R4", "odt", {odt_b, 14'h0, odt_a}, {e.odt, 14'h0, e.odt});
      check(cs_n_a == e.cs && cs_n_b == e.cs, "R5", "cs_n", {cs_n_b, 14'h0, cs_n_a}, {e.cs, 14'h0, e.cs});
      check(err_n == e.err_n, e.tag, "err_n", 32'(err_n), 32'(e.err_n));
    end
  end

  function automatic logic [21:0] next_word(input logic [21:0] x);
    return {x[20:0], x[21] ^ x[20]};
  endfunction

  initial begin
    // R9: reset state
    for (int i = 0; i < 3; i++) step(22'h3FFFFF, 4'h0, 1'b0, 2'b11, 2'b11, 1'b0, 1'b1, "R9");
    // R3: ungated, selects all high, data still follows
    for (int i = 0; i < 8; i++) begin
      lfsr = next_word(lfsr);
      step(lfsr, 4'hF, 1'b0, 2'(i), 2'(i + 1), 1'b0, 1'b0, "R3");
    end
    // R2: gated, all selects high -> hold
    for (int i = 0; i < 3; i++) begin
      lfsr = next_word(lfsr);
      step(lfsr, 4'hF, 1'b1, 2'(i), 2'(i), 1'b0, 1'b0, "R2");
    end
    // R2: each select alone opens the gate, including bits 3 and 2
    step(22'h155555, 4'b0111, 1'b1, 2'b01, 2'b10, 1'b0, 1'b0, "R2");
    step(22'h2AAAAA, 4'b1011, 1'b1, 2'b10, 2'b01, 1'b0, 1'b0, "R2");
    step(22'h0F0F0F, 4'b1110, 1'b1, 2'b11, 2'b00, 1'b0, 1'b0, "R2");
    step(22'h30F0F0, 4'b1101, 1'b1, 2'b00, 2'b11, 1'b0, 1'b0, "R2");
    // R7: single fault on an accepted word, then watch the pulse
    step(22'h000001, 4'b1110, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, "R7");
    step(22'h000003, 4'b1110, 1'b1, 2'b00, 2'b00, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 6; i++) step(22'h000003, 4'b1110, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, "R7");
    // R6: faulty parity on a gated-out word raises nothing
    step(22'h000007, 4'hF, 1'b1, 2'b01, 2'b01, 1'b0, 1'b0, "R6");
    step(22'h000007, 4'hF, 1'b1, 2'b01, 2'b01, 1'b1, 1'b0, "R6");
    for (int i = 0; i < 5; i++) step(22'h000007, 4'hF, 1'b1, 2'b01, 2'b01, 1'b0, 1'b0, "R6");
    // R6: faulty parity with gating off is checked
    step(22'h123456, 4'hF, 1'b0, 2'b10, 2'b10, 1'b0, 1'b0, "R6");
    step(22'h123457, 4'hF, 1'b0, 2'b10, 2'b10, 1'b1, 1'b0, "R6");
    for (int i = 0; i < 5; i++) step(22'h000000, 4'hF, 1'b0, 2'b10, 2'b10, 1'b0, 1'b0, "R6");
    // R8: back-to-back faults and one two edges later merge the pulse
    step(22'h0000F0, 4'b1100, 1'b1, 2'b11, 2'b11, 1'b0, 1'b0, "R8");
    step(22'h0000F1, 4'b1100, 1'b1, 2'b11, 2'b11, 1'b1, 1'b0, "R8");
    step(22'h0000F2, 4'b1100, 1'b1, 2'b11, 2'b11, 1'b1, 1'b0, "R8");
    step(22'h0000F3, 4'b1100, 1'b1, 2'b11, 2'b11, 1'b0, 1'b0, "R8");
    step(22'h0000F4, 4'b1100, 1'b1, 2'b11, 2'b11, 1'b1, 1'b0, "R8");
    for (int i = 0; i < 6; i++) step(22'h0000F4, 4'b1100, 1'b1, 2'b11, 2'b11, 1'b0, 1'b0, "R8");
    // R9: reset in the middle of a pending fault discards it
    step(22'h00AA00, 4'b1110, 1'b0, 2'b01, 2'b10, 1'b0, 1'b0, "R9");
    step(22'h00AA01, 4'b1110, 1'b0, 2'b01, 2'b10, 1'b1, 1'b0, "R9");
    step(22'h00AA01, 4'b1110, 1'b0, 2'b01, 2'b10, 1'b0, 1'b1, "R9");
    for (int i = 0; i < 6; i++) step(22'h00AA01, 4'b1110, 1'b0, 2'b01, 2'b10, 1'b0, 1'b0, "R9");
    // Drain
    while (sb_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1..all: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule